// File: doc/BRIEF.md
# Ethernet DMA Control and Status Register File

This block is the host-facing register file of a descriptor-driven Ethernet DMA engine. A host reaches it through 32-bit word accesses whose word index is the byte address with its two low bits dropped. It keeps the engine's operating state: bus mode, the control word with the receive and transmit enables, the interrupt enable mask, a sticky event status word, and, for each of the two descriptor rings, a base address and a current-descriptor pointer.

The transmit and receive engines talk to the block through single-cycle event pulses, which set status bits, and through descriptor-done pulses, which move the ring pointers. A write to the transmit poll word stores nothing. It fires a one-cycle kick that starts the transmit descriptor walk. A single level interrupt is raised while any enabled status bit is set.

Word map: 0 bus mode, 1 control, 2 interrupt enable, 3 status, 4 transmit poll, 5 receive ring base, 6 transmit ring base, 7 current receive descriptor, 8 current transmit descriptor, 9 version.

Top module: `dma_csr_block`

## Requirements
- R1: After reset every stored register (words 0 to 8) reads zero, word 9 reads 0x00001012, and `irq`, `tx_kick`, `rx_enable` and `tx_enable` are low.
- R2: A host write to the status word (word 3) clears each status bit that is 1 in the written data and leaves every other bit as it was.
- R3: When an engine event sets a status bit in the same cycle that a host write clears that bit, the bit ends up set.
- R4: `irq` is registered. On the clock edge that applies a register write or an event, it becomes high exactly when the updated status ANDed with the updated interrupt enable (word 2) is non-zero.
- R5: A write to the receive ring base (word 5) loads the base and the current receive pointer (word 7) with the written value in the same cycle. The transmit ring base (word 6) does the same for the current transmit pointer (word 8).
- R6: A write to the transmit poll word (word 4) makes `tx_kick` high for exactly the next cycle. Nothing is stored, and the word reads zero.
- R7: A write to the bus mode word (word 0) stores the data with bit 0 forced to zero.
- R8: The version word (word 9) always reads 0x00001012, and writes to it are ignored.
- R9: `rx_enable` follows bit 1 of the control word (word 1), and `tx_enable` follows bit 13.
- R10: A descriptor-done pulse advances that ring's current pointer by DESC_BYTES (32 by default). With the wrap input high, it reloads the ring base instead. A host base write in the same cycle takes priority.
- R11: Reads of any word index above 9 return zero. Host writes to such indices, and to the current-pointer words 7 and 8, change no register.
- R12: Event pulses set fixed status bits. Transmit done sets bit 0, transmit stopped bit 1, transmit buffer unavailable bit 2, receive done bit 6 and receive buffer unavailable bit 7. Transmit done, transmit buffer unavailable and receive done also set the normal summary bit 16. Transmit stopped and receive buffer unavailable set the abnormal summary bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host byte address; word index is bits ADDR_W-1:2 |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Read data for host_addr (combinational) |
| tx_done_evt | input | 1 | Transmit frame completed pulse |
| tx_stop_evt | input | 1 | Transmit process stopped pulse |
| tx_nobuf_evt | input | 1 | Transmit buffer unavailable pulse |
| rx_done_evt | input | 1 | Receive frame completed pulse |
| rx_nobuf_evt | input | 1 | Receive buffer unavailable pulse |
| tx_desc_done | input | 1 | Transmit descriptor handed back |
| tx_desc_wrap | input | 1 | That transmit descriptor ends the ring |
| rx_desc_done | input | 1 | Receive descriptor handed back |
| rx_desc_wrap | input | 1 | That receive descriptor ends the ring |
| irq | output | 1 | Level interrupt |
| tx_kick | output | 1 | One-cycle transmit start pulse |
| rx_enable | output | 1 | Receive enable from control word |
| tx_enable | output | 1 | Transmit enable from control word |
| cur_tx_desc | output | DATA_W | Current transmit descriptor pointer |
| cur_rx_desc | output | DATA_W | Current receive descriptor pointer |

## Verification
The assertions watch on every cycle the rules that can be seen at the ports. A kick appears only after a poll write, and always after one. A receive base write lands in the current pointer. A plain transmit descriptor-done steps the pointer by the stride. The interrupt rises only after an event or an enable write, and the enables stay put unless the control word is written. The bench scenarios are needed for the status word itself: clear-on-write-1, the exact bit and summary pattern of each event, set winning over clear, wrap and priority on the rings, masking of the bus mode bit, the fixed version, and writes that must be ignored.

// File: rtl/dma_csr_pkg.sv
`timescale 1ns/1ps
package dma_csr_pkg;

    // Word indices of the register map
    localparam int NUM_REGS      = 10;
    localparam int IDX_BUS_MODE  = 0;
    localparam int IDX_CONTROL   = 1;
    localparam int IDX_IRQ_EN    = 2;
    localparam int IDX_STATUS    = 3;
    localparam int IDX_TX_POLL   = 4;
    localparam int IDX_RX_BASE   = 5;
    localparam int IDX_TX_BASE   = 6;
    localparam int IDX_RX_CUR    = 7;
    localparam int IDX_TX_CUR    = 8;
    localparam int IDX_VERSION   = 9;

    localparam logic [31:0] VERSION_ID = 32'h0000_1012;

    // Control word fields
    localparam int CTRL_RX_BIT = 1;
    localparam int CTRL_TX_BIT = 13;

    // Status word bit positions (decoded by host software)
    localparam int BIT_TX_DONE  = 0;
    localparam int BIT_TX_STOP  = 1;
    localparam int BIT_TX_NOBUF = 2;
    localparam int BIT_RX_DONE  = 6;
    localparam int BIT_RX_NOBUF = 7;
    localparam int BIT_ABN_SUM  = 15;
    localparam int BIT_NRM_SUM  = 16;

    // Engine event vector layout
    localparam int NUM_EVT      = 5;
    localparam int EVT_TX_DONE  = 0;
    localparam int EVT_TX_STOP  = 1;
    localparam int EVT_TX_NOBUF = 2;
    localparam int EVT_RX_DONE  = 3;
    localparam int EVT_RX_NOBUF = 4;

    // Ring slots
    localparam int NUM_RINGS = 2;
    localparam int RING_RX   = 0;
    localparam int RING_TX   = 1;

    function automatic int evt_bit(input int e);
        case (e)
            EVT_TX_DONE:  return BIT_TX_DONE;
            EVT_TX_STOP:  return BIT_TX_STOP;
            EVT_TX_NOBUF: return BIT_TX_NOBUF;
            EVT_RX_DONE:  return BIT_RX_DONE;
            EVT_RX_NOBUF: return BIT_RX_NOBUF;
            default:      return BIT_TX_DONE;
        endcase
    endfunction

    function automatic logic evt_abnormal(input int e);
        return (e == EVT_TX_STOP) || (e == EVT_RX_NOBUF);
    endfunction

endpackage

// File: rtl/dma_csr_decode.sv
`timescale 1ns/1ps
module dma_csr_decode #(
    parameter int ADDR_W   = 12,
    parameter int NUM_REGS = 10,
    localparam int IDX_W   = ADDR_W - 2
) (
    input  logic                host_wr,
    input  logic [ADDR_W-1:0]   host_addr,
    output logic [NUM_REGS-1:0] wr_sel,
    output logic [IDX_W-1:0]    rd_idx
);

    assign rd_idx = host_addr[ADDR_W-1:2];

    // One write strobe per implemented word
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
        assign wr_sel[i] = host_wr && (rd_idx == IDX_W'(i));
    end

endmodule

// File: rtl/dma_csr_status.sv
`timescale 1ns/1ps
module dma_csr_status
    import dma_csr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_en,
    input  logic [DATA_W-1:0]  clr_mask,
    input  logic [NUM_EVT-1:0] evt,
    output logic [DATA_W-1:0]  status_d,
    output logic [DATA_W-1:0]  status_q
);

    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] keep_mask;

    always_comb begin
        set_vec = '0;
        for (int e = 0; e < NUM_EVT; e++) begin
            if (evt[e]) begin
                set_vec[evt_bit(e)] = 1'b1;
                if (evt_abnormal(e)) begin
                    set_vec[BIT_ABN_SUM] = 1'b1;
                end else begin
                    set_vec[BIT_NRM_SUM] = 1'b1;
                end
            end
        end
        keep_mask = clr_en ? ~clr_mask : '1;
        // Set is applied after clear, so a colliding set wins
        status_d  = (status_q & keep_mask) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= status_d;
        end
    end

endmodule

// File: rtl/dma_csr_ring.sv
`timescale 1ns/1ps
module dma_csr_ring #(
    parameter int DATA_W     = 32,
    parameter int DESC_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_wr,
    input  logic [DATA_W-1:0] base_val,
    input  logic              desc_done,
    input  logic              desc_wrap,
    output logic [DATA_W-1:0] base_q,
    output logic [DATA_W-1:0] cur_q
);

    typedef struct packed {
        logic [DATA_W-1:0] base;
        logic [DATA_W-1:0] cur;
    } ring_t;

    ring_t ring_d, ring_q;

    always_comb begin
        ring_d = ring_q;
        if (base_wr) begin
            ring_d.base = base_val;
            ring_d.cur  = base_val;
        end else if (desc_done) begin
            ring_d.cur = desc_wrap ? ring_q.base
                                   : ring_q.cur + DATA_W'(DESC_BYTES);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_q <= '0;
        end else begin
            ring_q <= ring_d;
        end
    end

    assign base_q = ring_q.base;
    assign cur_q  = ring_q.cur;

endmodule

// File: rtl/dma_csr_block.sv
`timescale 1ns/1ps
module dma_csr_block
    import dma_csr_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int DESC_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              tx_done_evt,
    input  logic              tx_stop_evt,
    input  logic              tx_nobuf_evt,
    input  logic              rx_done_evt,
    input  logic              rx_nobuf_evt,
    input  logic              tx_desc_done,
    input  logic              tx_desc_wrap,
    input  logic              rx_desc_done,
    input  logic              rx_desc_wrap,
    output logic              irq,
    output logic              tx_kick,
    output logic              rx_enable,
    output logic              tx_enable,
    output logic [DATA_W-1:0] cur_tx_desc,
    output logic [DATA_W-1:0] cur_rx_desc
);

    localparam int IDX_W = ADDR_W - 2;

    typedef struct packed {
        logic [DATA_W-1:0] bus_mode;
        logic [DATA_W-1:0] control;
        logic [DATA_W-1:0] irq_en;
        logic              kick;
        logic              irq;
    } csr_t;

    csr_t csr_d, csr_q;

    logic [NUM_REGS-1:0]  wr_sel;
    logic [IDX_W-1:0]     rd_idx;
    logic [NUM_EVT-1:0]   evt;
    logic [DATA_W-1:0]    status_d, status_q;
    logic [NUM_RINGS-1:0] ring_base_wr, ring_done, ring_wrap;
    logic [DATA_W-1:0]    ring_base [NUM_RINGS];
    logic [DATA_W-1:0]    ring_cur  [NUM_RINGS];

    dma_csr_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS)
    ) u_decode (
        .host_wr   (host_wr),
        .host_addr (host_addr),
        .wr_sel    (wr_sel),
        .rd_idx    (rd_idx)
    );

    always_comb begin
        evt               = '0;
        evt[EVT_TX_DONE]  = tx_done_evt;
        evt[EVT_TX_STOP]  = tx_stop_evt;
        evt[EVT_TX_NOBUF] = tx_nobuf_evt;
        evt[EVT_RX_DONE]  = rx_done_evt;
        evt[EVT_RX_NOBUF] = rx_nobuf_evt;
    end

    dma_csr_status #(
        .DATA_W (DATA_W)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (wr_sel[IDX_STATUS]),
        .clr_mask (host_wdata),
        .evt      (evt),
        .status_d (status_d),
        .status_q (status_q)
    );

    always_comb begin
        ring_base_wr          = '0;
        ring_done             = '0;
        ring_wrap             = '0;
        ring_base_wr[RING_RX] = wr_sel[IDX_RX_BASE];
        ring_base_wr[RING_TX] = wr_sel[IDX_TX_BASE];
        ring_done[RING_RX]    = rx_desc_done;
        ring_done[RING_TX]    = tx_desc_done;
        ring_wrap[RING_RX]    = rx_desc_wrap;
        ring_wrap[RING_TX]    = tx_desc_wrap;
    end

    for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
        dma_csr_ring #(
            .DATA_W     (DATA_W),
            .DESC_BYTES (DESC_BYTES)
        ) u_ring (
            .clk       (clk),
            .rst_n     (rst_n),
            .base_wr   (ring_base_wr[r]),
            .base_val  (host_wdata),
            .desc_done (ring_done[r]),
            .desc_wrap (ring_wrap[r]),
            .base_q    (ring_base[r]),
            .cur_q     (ring_cur[r])
        );
    end

    // Next-state of the locally held registers and outputs
    always_comb begin
        csr_d      = csr_q;
        csr_d.kick = wr_sel[IDX_TX_POLL];
        if (wr_sel[IDX_BUS_MODE]) begin
            csr_d.bus_mode = host_wdata & ~DATA_W'(1);
        end
        if (wr_sel[IDX_CONTROL]) begin
            csr_d.control = host_wdata;
        end
        if (wr_sel[IDX_IRQ_EN]) begin
            csr_d.irq_en = host_wdata;
        end
        csr_d.irq = |(status_d & csr_d.irq_en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr_q <= '0;
        end else begin
            csr_q <= csr_d;
        end
    end

    // Read multiplexer
    always_comb begin
        case (int'(rd_idx))
            IDX_BUS_MODE: host_rdata = csr_q.bus_mode;
            IDX_CONTROL:  host_rdata = csr_q.control;
            IDX_IRQ_EN:   host_rdata = csr_q.irq_en;
            IDX_STATUS:   host_rdata = status_q;
            IDX_RX_BASE:  host_rdata = ring_base[RING_RX];
            IDX_TX_BASE:  host_rdata = ring_base[RING_TX];
            IDX_RX_CUR:   host_rdata = ring_cur[RING_RX];
            IDX_TX_CUR:   host_rdata = ring_cur[RING_TX];
            IDX_VERSION:  host_rdata = DATA_W'(VERSION_ID);
            default:      host_rdata = '0;
        endcase
    end

    assign irq         = csr_q.irq;
    assign tx_kick     = csr_q.kick;
    assign rx_enable   = csr_q.control[CTRL_RX_BIT];
    assign tx_enable   = csr_q.control[CTRL_TX_BIT];
    assign cur_tx_desc = ring_cur[RING_TX];
    assign cur_rx_desc = ring_cur[RING_RX];

endmodule

// File: rtl/dma_csr_checker.sv
`timescale 1ns/1ps
module dma_csr_checker
    import dma_csr_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int DESC_BYTES = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic [ADDR_W-1:0] host_addr,
    input logic [DATA_W-1:0] host_wdata,
    input logic              tx_done_evt,
    input logic              tx_stop_evt,
    input logic              tx_nobuf_evt,
    input logic              rx_done_evt,
    input logic              rx_nobuf_evt,
    input logic              tx_desc_done,
    input logic              tx_desc_wrap,
    input logic              irq,
    input logic              tx_kick,
    input logic              rx_enable,
    input logic              tx_enable,
    input logic [DATA_W-1:0] cur_tx_desc,
    input logic [DATA_W-1:0] cur_rx_desc
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             any_evt;
    assign idx     = host_addr[ADDR_W-1:2];
    assign any_evt = tx_done_evt | tx_stop_evt | tx_nobuf_evt | rx_done_evt | rx_nobuf_evt;

    a_r6_kick_follows_poll: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && idx == IDX_W'(IDX_TX_POLL)) |=> tx_kick);

    a_r6_kick_needs_poll: assert property (@(posedge clk) disable iff (!rst_n)
        tx_kick |-> $past(host_wr && idx == IDX_W'(IDX_TX_POLL)));

    a_r5_rx_base_loads_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && idx == IDX_W'(IDX_RX_BASE)) |=> (cur_rx_desc == $past(host_wdata)));

    a_r10_tx_ptr_stride: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_desc_done && !tx_desc_wrap && !(host_wr && idx == IDX_W'(IDX_TX_BASE)))
        |=> (cur_tx_desc == $past(cur_tx_desc) + DATA_W'(DESC_BYTES)));

    a_r4_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(any_evt || (host_wr && idx == IDX_W'(IDX_IRQ_EN))));

    a_r9_enables_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && idx == IDX_W'(IDX_CONTROL)) |=> ($stable(rx_enable) && $stable(tx_enable)));

endmodule

bind dma_csr_block dma_csr_checker #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .DESC_BYTES (DESC_BYTES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr      (host_wr),
    .host_addr    (host_addr),
    .host_wdata   (host_wdata),
    .tx_done_evt  (tx_done_evt),
    .tx_stop_evt  (tx_stop_evt),
    .tx_nobuf_evt (tx_nobuf_evt),
    .rx_done_evt  (rx_done_evt),
    .rx_nobuf_evt (rx_nobuf_evt),
    .tx_desc_done (tx_desc_done),
    .tx_desc_wrap (tx_desc_wrap),
    .irq          (irq),
    .tx_kick      (tx_kick),
    .rx_enable    (rx_enable),
    .tx_enable    (tx_enable),
    .cur_tx_desc  (cur_tx_desc),
    .cur_rx_desc  (cur_rx_desc)
);

// File: tb/sim_dma_csr_block.sv
`timescale 1ns/1ps
module sim_dma_csr_block;

    localparam int W_BUS = 0, W_CTRL = 1, W_IEN = 2, W_STAT = 3, W_POLL = 4;
    localparam int W_RXB = 5, W_TXB = 6, W_RXC = 7, W_TXC = 8, W_VER = 9;
    localparam int K_RD = 0, K_IRQ = 1, K_KICK = 2, K_RXEN = 3, K_TXEN = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [11:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [4:0]  ev = '0;      // {rx_nobuf, rx_done, tx_nobuf, tx_stop, tx_done}
    logic [3:0]  rg = '0;      // {rx_wrap, rx_done, tx_wrap, tx_done}
    logic        irq, tx_kick, rx_enable, tx_enable;
    logic [31:0] cur_tx_desc, cur_rx_desc;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t exp_q[$];

    always #2 clk = ~clk;

    dma_csr_block u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_wr      (host_wr),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .host_rdata   (host_rdata),
        .tx_done_evt  (ev[0]),
        .tx_stop_evt  (ev[1]),
        .tx_nobuf_evt (ev[2]),
        .rx_done_evt  (ev[3]),
        .rx_nobuf_evt (ev[4]),
        .tx_desc_done (rg[0]),
        .tx_desc_wrap (rg[1]),
        .rx_desc_done (rg[2]),
        .rx_desc_wrap (rg[3]),
        .irq          (irq),
        .tx_kick      (tx_kick),
        .rx_enable    (rx_enable),
        .tx_enable    (tx_enable),
        .cur_tx_desc  (cur_tx_desc),
        .cur_rx_desc  (cur_rx_desc)
    );

    // Monitor: compares queued expectations at the falling edge
    always @(negedge clk) begin
        item_t it;
        logic [31:0] act;
        while (exp_q.size() > 0) begin
            it = exp_q.pop_front();
            case (it.kind)
                K_RD:    act = host_rdata;
                K_IRQ:   act = {31'b0, irq};
                K_KICK:  act = {31'b0, tx_kick};
                K_RXEN:  act = {31'b0, rx_enable};
                default: act = {31'b0, tx_enable};
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: kind %0d actual %h expected %h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    task automatic push(input int kind, input logic [31:0] e, input string tag);
        item_t it;
        it.kind = kind;
        it.exp  = e;
        it.tag  = tag;
        exp_q.push_back(it);
    endtask

    task automatic drive(input bit wr, input int idx, input logic [31:0] d,
                         input logic [4:0] evs, input logic [3:0] rgs);
        @(posedge clk);
        #1;
        host_wr    = wr;
        host_addr  = 12'(idx * 4);
        host_wdata = d;
        ev         = evs;
        rg         = rgs;
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        drive(1'b1, idx, d, 5'b0, 4'b0);
    endtask

    task automatic step();
        drive(1'b0, 0, 32'h0, 5'b0, 4'b0);
    endtask

    task automatic rd(input int idx, input logic [31:0] e, input string tag);
        drive(1'b0, idx, 32'h0, 5'b0, 4'b0);
        push(K_RD, e, tag);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(W_BUS, 32'h0, "R1");
        push(K_IRQ, 0, "R1"); push(K_KICK, 0, "R1");
        push(K_RXEN, 0, "R1"); push(K_TXEN, 0, "R1");
        rd(W_CTRL, 32'h0, "R1");
        rd(W_IEN, 32'h0, "R1");
        rd(W_STAT, 32'h0, "R1");
        rd(W_RXC, 32'h0, "R1");
        rd(W_TXB, 32'h0, "R1");
        rd(W_VER, 32'h0000_1012, "R1");

        // R7 bus mode bit 0 forced low
        wr(W_BUS, 32'hFFFF_FFFF);
        rd(W_BUS, 32'hFFFF_FFFE, "R7");
        wr(W_BUS, 32'h0000_0081);
        rd(W_BUS, 32'h0000_0080, "R7");

        // R8 version is constant
        wr(W_VER, 32'hDEAD_BEEF);
        rd(W_VER, 32'h0000_1012, "R8");

        // R9 enables from control bits 1 and 13
        wr(W_CTRL, 32'h0000_2002);
        step();
        push(K_RXEN, 1, "R9"); push(K_TXEN, 1, "R9");
        wr(W_CTRL, 32'h0000_0002);
        step();
        push(K_RXEN, 1, "R9"); push(K_TXEN, 0, "R9");
        wr(W_CTRL, 32'h0000_2000);
        rd(W_CTRL, 32'h0000_2000, "R9");
        push(K_RXEN, 0, "R9"); push(K_TXEN, 1, "R9");

        // R5 base writes load current pointers
        wr(W_RXB, 32'h0000_1000);
        rd(W_RXC, 32'h0000_1000, "R5");
        rd(W_RXB, 32'h0000_1000, "R5");
        wr(W_TXB, 32'h0000_2000);
        rd(W_TXC, 32'h0000_2000, "R5");

        // R10 descriptor advance, wrap, host priority
        drive(1'b0, 0, 0, 5'b0, 4'b0100);
        rd(W_RXC, 32'h0000_1020, "R10");
        drive(1'b0, 0, 0, 5'b0, 4'b0100);
        rd(W_RXC, 32'h0000_1040, "R10");
        drive(1'b0, 0, 0, 5'b0, 4'b1100);
        rd(W_RXC, 32'h0000_1000, "R10");
        drive(1'b0, 0, 0, 5'b0, 4'b0001);
        rd(W_TXC, 32'h0000_2020, "R10");
        drive(1'b1, W_TXB, 32'h0000_3000, 5'b0, 4'b0001);
        rd(W_TXC, 32'h0000_3000, "R10");
        drive(1'b0, 0, 0, 5'b0, 4'b0001);
        rd(W_TXC, 32'h0000_3020, "R10");
        drive(1'b0, 0, 0, 5'b0, 4'b0011);
        rd(W_TXC, 32'h0000_3000, "R10");

        // R11 ignored writes and unmapped reads
        wr(W_RXC, 32'h0000_0055);
        rd(W_RXC, 32'h0000_1000, "R11");
        wr(W_TXC, 32'h0000_0077);
        rd(W_TXC, 32'h0000_3000, "R11");
        rd(15, 32'h0, "R11");
        wr(15, 32'h0000_ABCD);
        rd(15, 32'h0, "R11");
        rd(W_BUS, 32'h0000_0080, "R11");

        // R6 poll demand kick
        wr(W_POLL, 32'h0000_0001);
        step();
        push(K_KICK, 1, "R6");
        step();
        push(K_KICK, 0, "R6");
        rd(W_POLL, 32'h0, "R6");

        // R12 / R4 / R2 / R3 status and interrupt
        drive(1'b0, 0, 0, 5'b00001, 4'b0);
        rd(W_STAT, 32'h0001_0001, "R12");
        push(K_IRQ, 0, "R4");
        wr(W_IEN, 32'h0000_0001);
        step();
        push(K_IRQ, 1, "R4");
        wr(W_STAT, 32'h0000_0001);
        rd(W_STAT, 32'h0001_0000, "R2");
        push(K_IRQ, 0, "R4");
        drive(1'b0, 0, 0, 5'b10000, 4'b0);
        rd(W_STAT, 32'h0001_8080, "R12");
        wr(W_STAT, 32'hFFFF_FFFF);
        rd(W_STAT, 32'h0, "R2");
        drive(1'b0, 0, 0, 5'b01000, 4'b0);
        rd(W_STAT, 32'h0001_0040, "R12");
        drive(1'b1, W_STAT, 32'h0001_0040, 5'b01000, 4'b0);
        rd(W_STAT, 32'h0001_0040, "R3");
        wr(W_STAT, 32'hFFFF_FFFF);
        drive(1'b0, 0, 0, 5'b00010, 4'b0);
        rd(W_STAT, 32'h0000_8002, "R12");
        drive(1'b0, 0, 0, 5'b00100, 4'b0);
        rd(W_STAT, 32'h0001_8006, "R12");
        push(K_IRQ, 0, "R4");
        wr(W_IEN, 32'h0000_0004);
        step();
        push(K_IRQ, 1, "R4");
        drive(1'b1, W_STAT, 32'h0000_0004, 5'b00100, 4'b0);
        rd(W_STAT, 32'h0001_8006, "R3");
        push(K_IRQ, 1, "R3");

        step();
        @(negedge clk);
        #1;
        finish_run();
    end

endmodule